// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks which of `NUM_FRAMES` physical frames to give up when a new page needs a home. It uses the second-chance policy. Each frame owns a single usage flag. A circular hand marks where the next search begins. Whenever a frame is touched, the reference port raises that frame's flag. A search looks at one frame per clock cycle, starting at the hand. In the default single-hand variant, a frame with its flag raised is given another chance: its flag is lowered and the hand moves on. The first frame found with its flag low is reported as the victim, and the hand is left on the frame after it.

Setting `TWO_HAND` selects a second variant. A leading hand runs `HAND_GAP` frames ahead of the trailing hand and lowers every flag it passes. The trailing hand no longer lowers flags. It only stops on a frame whose flag is already low. The distance between the hands is fixed, so a frame touched after the leading hand cleared it keeps its place.

A request enters on a valid/ready pair. `evict_req_ready` is high only while the selector is idle. The result leaves on a second valid/ready pair. `victim_valid` and `victim_idx` hold steady until the consumer raises `victim_ready`. Until then no new request is taken. The reference port has no back-pressure. A frame index is a plain binary frame number on both `ref_index` and `victim_idx`.

Top module: `clock_victim_sel`

## Requirements
- R1: Synchronous reset lowers every usage flag and puts the trailing hand at frame 0 (leading hand at frame `HAND_GAP`). After reset `evict_req_ready` is 1 and `victim_valid` is 0, so a first search returns frame 0 after one examined frame.
- R2: A cycle with `ref_valid` high raises the flag of frame `ref_index`, and it stays raised until a hand lowers it.
- R3: In single-hand mode a search examines one frame per cycle from the hand. Each raised flag it meets is lowered and the hand advances. The first frame with a low flag is the victim, and the number of frames examined is its circular distance from the start plus one.
- R4: When every flag is raised at the start of a single-hand search, all flags are lowered and the starting frame is the victim after `NUM_FRAMES`+1 examined frames.
- R5: After a victim is reported the hand rests on the next frame (wrapping from `NUM_FRAMES`-1 to 0), and the next search starts there. The hand does not move between searches.
- R6: A reference to the frame whose flag a hand lowers in that same cycle wins, and the flag stays raised.
- R7: In two-hand mode the leading hand is always `HAND_GAP` frames ahead of the trailing hand and lowers the flag under it on every searched cycle. The trailing hand lowers no flag and stops at the first frame with a low flag.
- R8: A request is taken on a cycle where `evict_req_valid` and `evict_req_ready` are both high. `evict_req_ready` stays low from then until the result is consumed, and a request held high meanwhile starts nothing.
- R9: While `victim_valid` is high and `victim_ready` is low, `victim_valid` stays high and `victim_idx` does not change. The result is gone one cycle after `victim_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | A frame was used this cycle |
| ref_index | input | $clog2(NUM_FRAMES) | Binary number of the used frame |
| evict_req_valid | input | 1 | Request for a victim |
| evict_req_ready | output | 1 | High while idle and able to take a request |
| victim_valid | output | 1 | Victim result available |
| victim_ready | input | 1 | Consumer takes the result |
| victim_idx | output | $clog2(NUM_FRAMES) | Binary number of the chosen frame |

## Verification
The properties assume `NUM_FRAMES` is a power of two of at least 2, and that `HAND_GAP` lies between 1 and `NUM_FRAMES`-1. They also assume `ref_index` always names an existing frame. The hand-gap and stability properties need no promise on the consumer, because back-pressure may last any length of time. The stimulus only sends references to frames below `NUM_FRAMES`. It raises a request only while the selector is idle, except in the one case that holds a request high against a pending result to check that it is ignored. It also pins the reference/clear collision to a known cycle, so the number of examined frames in every search can be predicted exactly.

// File: rtl/clk_repl_pkg.sv
package clk_repl_pkg;
  typedef enum logic [1:0] {
    SWEEP_IDLE = 2'd0,
    SWEEP_SCAN = 2'd1,
    SWEEP_HOLD = 2'd2
  } sweep_state_e;
endpackage

// File: rtl/ref_bit_array.sv
module ref_bit_array #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_en,
  input  logic [IDX_W-1:0]      set_idx,
  input  logic                  clr_a_en,
  input  logic [IDX_W-1:0]      clr_a_idx,
  input  logic                  clr_b_en,
  input  logic [IDX_W-1:0]      clr_b_idx,
  output logic [NUM_FRAMES-1:0] ref_bits
);

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_flag
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_idx == IDX_W'(g));
    assign hit_clr = (clr_a_en && (clr_a_idx == IDX_W'(g))) ||
                     (clr_b_en && (clr_b_idx == IDX_W'(g)));
    // a use in the same cycle outranks any clear
    always_ff @(posedge clk) begin
      if (rst)          ref_bits[g] <= 1'b0;
      else if (hit_set) ref_bits[g] <= 1'b1;
      else if (hit_clr) ref_bits[g] <= 1'b0;
    end
  end

  AST_USE_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ref_bits[$past(set_idx)]); // R2

  AST_COLLIDE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (set_en && clr_a_en && set_idx == clr_a_idx) |=> ref_bits[$past(clr_a_idx)]); // R6

  AST_CLEAR_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (clr_a_en && !(set_en && set_idx == clr_a_idx)) |=> !ref_bits[$past(clr_a_idx)]); // R3

endmodule

// File: rtl/hand_ring.sv
module hand_ring #(
  parameter int NUM_FRAMES = 8,
  parameter int TWO_HAND   = 0,
  parameter int HAND_GAP   = 2,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] trail,
  output logic [IDX_W-1:0] lead
);

  function automatic logic [IDX_W-1:0] wrap_next(input logic [IDX_W-1:0] h);
    return (h == IDX_W'(NUM_FRAMES - 1)) ? '0 : h + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          trail <= '0;
    else if (advance) trail <= wrap_next(trail);
  end

  if (TWO_HAND != 0) begin : g_lead
    always_ff @(posedge clk) begin
      if (rst)          lead <= IDX_W'(HAND_GAP);
      else if (advance) lead <= wrap_next(lead);
    end

    AST_HAND_GAP: assert property (@(posedge clk) disable iff (rst)
      ((int'(lead) + NUM_FRAMES - int'(trail)) % NUM_FRAMES) == HAND_GAP); // R7
  end else begin : g_single
    assign lead = trail;
  end

  AST_HAND_RESTS: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(trail)); // R5

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import clk_repl_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [IDX_W-1:0] res_idx,
  input  logic [IDX_W-1:0] trail,
  input  logic             cur_bit,
  output logic             scanning
);

  sweep_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SWEEP_IDLE;
      res_idx <= '0;
    end else begin
      case (state)
        SWEEP_IDLE: if (req_valid) state <= SWEEP_SCAN;
        SWEEP_SCAN: if (!cur_bit) begin
          res_idx <= trail;
          state   <= SWEEP_HOLD;
        end
        SWEEP_HOLD: if (res_ready) state <= SWEEP_IDLE;
        default:    state <= SWEEP_IDLE;
      endcase
    end
  end

  assign req_ready = (state == SWEEP_IDLE);
  assign res_valid = (state == SWEEP_HOLD);
  assign scanning  = (state == SWEEP_SCAN);

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_idx))); // R9

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
    (res_valid || scanning) |-> !req_ready); // R8

  AST_RESULT_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ready) |=> !res_valid); // R9

  AST_VICTIM_WAS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> !$past(cur_bit)); // R3

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_FRAMES = 8,
  parameter int TWO_HAND   = 0,
  parameter int HAND_GAP   = 2,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_index,
  input  logic             evict_req_valid,
  output logic             evict_req_ready,
  output logic             victim_valid,
  input  logic             victim_ready,
  output logic [IDX_W-1:0] victim_idx
);

  localparam bit TRAIL_CLEARS = (TWO_HAND == 0);

  logic [NUM_FRAMES-1:0] ref_bits;
  logic [IDX_W-1:0]      trail, lead;
  logic                  cur_bit, scanning;
  logic                  clr_trail_en, clr_lead_en;

  assign cur_bit      = ref_bits[trail];
  assign clr_trail_en = scanning && cur_bit && TRAIL_CLEARS;
  assign clr_lead_en  = scanning && !TRAIL_CLEARS;

  ref_bit_array #(.NUM_FRAMES(NUM_FRAMES)) i_flags (
    .clk       (clk),
    .rst       (rst),
    .set_en    (ref_valid),
    .set_idx   (ref_index),
    .clr_a_en  (clr_trail_en),
    .clr_a_idx (trail),
    .clr_b_en  (clr_lead_en),
    .clr_b_idx (lead),
    .ref_bits  (ref_bits)
  );

  hand_ring #(
    .NUM_FRAMES (NUM_FRAMES),
    .TWO_HAND   (TWO_HAND),
    .HAND_GAP   (HAND_GAP)
  ) i_hands (
    .clk     (clk),
    .rst     (rst),
    .advance (scanning),
    .trail   (trail),
    .lead    (lead)
  );

  sweep_ctrl #(.NUM_FRAMES(NUM_FRAMES)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (evict_req_valid),
    .req_ready (evict_req_ready),
    .res_valid (victim_valid),
    .res_ready (victim_ready),
    .res_idx   (victim_idx),
    .trail     (trail),
    .cur_bit   (cur_bit),
    .scanning  (scanning)
  );

  AST_SCAN_STEPS: assert property (@(posedge clk) disable iff (rst)
    scanning |=> (trail != $past(trail))); // R3

  AST_VICTIM_BEHIND_HAND: assert property (@(posedge clk) disable iff (rst)
    $rose(victim_valid) |-> (trail == ((victim_idx == IDX_W'(NUM_FRAMES - 1)) ? '0 : victim_idx + 1'b1))); // R5

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (evict_req_ready && !victim_valid)); // R1

endmodule

// File: tb/test_clock_victim_sel.sv
`timescale 1ns/1ps
module test_clock_victim_sel;
  localparam int CLK_NS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_NS/2) clk = ~clk;

  logic [1:0] req_valid = '0, req_ready, ref_valid = '0, vv, vr = '0;
  logic [2:0] ref_index [2];
  logic [2:0] vidx [2];
  int n_tests = 0, n_fail = 0;

  // dut 0: single hand; dut 1: two hands, gap 2
  clock_victim_sel #(.NUM_FRAMES(8), .TWO_HAND(0)) i_clock_victim_sel (
    .clk(clk), .rst(rst), .ref_valid(ref_valid[0]), .ref_index(ref_index[0]),
    .evict_req_valid(req_valid[0]), .evict_req_ready(req_ready[0]),
    .victim_valid(vv[0]), .victim_ready(vr[0]), .victim_idx(vidx[0]));

  clock_victim_sel #(.NUM_FRAMES(8), .TWO_HAND(1), .HAND_GAP(2)) i_clock_victim_sel_two (
    .clk(clk), .rst(rst), .ref_valid(ref_valid[1]), .ref_index(ref_index[1]),
    .evict_req_valid(req_valid[1]), .evict_req_ready(req_ready[1]),
    .victim_valid(vv[1]), .victim_ready(vr[1]), .victim_idx(vidx[1]));

  // {dut, reference mask, expected victim, expected frames examined}
  localparam logic [15:0] VEC [12] = '{
    {1'b0, 8'h00, 3'd0, 4'd1}, {1'b0, 8'h06, 3'd3, 4'd3},
    {1'b0, 8'hFF, 3'd4, 4'd9}, {1'b0, 8'hE0, 3'd0, 4'd4},
    {1'b0, 8'h01, 3'd1, 4'd1}, {1'b0, 8'h00, 3'd2, 4'd1},
    {1'b0, 8'hFC, 3'd1, 4'd7}, {1'b0, 8'h00, 3'd3, 4'd2},
    {1'b1, 8'hFF, 3'd2, 4'd3}, {1'b1, 8'h00, 3'd3, 4'd1},
    {1'b1, 8'h10, 3'd5, 4'd2}, {1'b1, 8'h00, 3'd6, 4'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic touch(input int d, input logic [7:0] mask);
    for (int i = 0; i < 8; i++) begin
      if (mask[i]) begin
        ref_valid[d] = 1'b1;
        ref_index[d] = 3'(i);
        @(posedge clk); #1;
        ref_valid[d] = 1'b0;
      end
    end
  endtask

  task automatic evict(input int d, input int exp_v, input int exp_k,
                       input int collide, input int hold, input string tag);
    int k;
    bit got;
    logic [2:0] first;
    k = 0; got = 1'b0;
    req_valid[d] = 1'b1;
    @(posedge clk); #1;
    req_valid[d] = 1'b0;
    if (collide >= 0) begin
      ref_valid[d] = 1'b1;
      ref_index[d] = 3'(collide);
    end
    while (!got && k < 40) begin
      @(posedge clk); #1;
      ref_valid[d] = 1'b0;
      k++;
      if (vv[d]) got = 1'b1;
    end
    chk(got && vidx[d] == 3'(exp_v), {tag, " victim"}, int'(vidx[d]), exp_v);
    chk(k == exp_k, {tag, " frames examined"}, k, exp_k);
    first = vidx[d];
    if (hold > 0) begin
      req_valid[d] = 1'b1;
      repeat (hold) begin @(posedge clk); #1; end
      chk(vv[d] == 1'b1 && vidx[d] == first, "R9 result held", int'(vidx[d]), int'(first));
      chk(req_ready[d] == 1'b0, "R8 ready low while pending", int'(req_ready[d]), 0);
      req_valid[d] = 1'b0;
    end
    vr[d] = 1'b1;
    @(posedge clk); #1;
    vr[d] = 1'b0;
    chk(vv[d] == 1'b0, {tag, " R9 result drained"}, int'(vv[d]), 0);
    chk(req_ready[d] == 1'b1, {tag, " R8 idle again"}, int'(req_ready[d]), 1);
  endtask

  initial begin
    #(CLK_NS * 50000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    ref_index[0] = '0; ref_index[1] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int d = 0; d < 2; d++) begin
      chk(req_ready[d] == 1'b1, "R1 reset ready", int'(req_ready[d]), 1);
      chk(vv[d] == 1'b0, "R1 reset no victim", int'(vv[d]), 0);
    end

    // vector walk: R1 R2 R3 R4 R5 on dut 0, R7 on dut 1
    for (int i = 0; i < 12; i++) begin
      int d;
      string tag;
      d = int'(VEC[i][15]);
      if (d == 1)                     tag = "R7";
      else if (VEC[i][14:7] == 8'hFF) tag = "R4";
      else if (i == 0)                tag = "R1";
      else                            tag = "R2 R3 R5";
      touch(d, VEC[i][14:7]);
      evict(d, int'(VEC[i][6:4]), int'(VEC[i][3:0]), -1, 0, tag);
    end

    // R6: use of frame 4 while the hand lowers its flag; hand at 4, all flags low
    touch(0, 8'h30);
    evict(0, 6, 3, 4, 0, "R6 collision search");
    evict(0, 7, 1, -1, 0, "R6 walk");
    evict(0, 0, 1, -1, 0, "R6 walk");
    evict(0, 1, 1, -1, 0, "R6 walk");
    evict(0, 2, 1, -1, 0, "R6 walk");
    evict(0, 3, 1, -1, 0, "R6 walk");
    evict(0, 5, 2, -1, 0, "R6 flag kept");

    // R8 R9: back-pressure on dut 1 (trail 7, flag 7 low)
    evict(1, 7, 1, -1, 3, "R8 R9 back-pressure");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule